// File: doc/BRIEF.md
# Early Load Result Qualifier

This block sits next to the read port of a level-one data cache in an in-order pipeline. Every load has a full-latency result that appears one stage after the cache array is read. For a restricted class of loads the block also provides the same value one cycle sooner, together with a flag that says whether that early value can be used. A consumer in the second execute stage may take the early value when the flag is high. Otherwise it waits for the normal result, which is always produced.

A load qualifies only when four conditions hold. It must be a word (32-bit) or doubleword (64-bit) access. Its address must be a multiple of its size. It must target ordinary RAM. No valid store-buffer entry may cover the same doubleword. The cache must also report a hit in the cycle the array data is presented. The early word is extracted and extended by a narrow word-select path. The normal result goes through a general byte shifter that handles every size and offset. Whenever the flag is set, the two paths give identical values.

Top module: `load_early_fwd`

## Requirements
- R1: Only size codes 2 (32-bit) and 3 (64-bit) may set `early_valid`. Size codes 0 (8-bit) and 1 (16-bit) never do.
- R2: A 32-bit load whose `req_addr[1:0]` is not zero, or a 64-bit load whose `req_addr[2:0]` is not zero, never sets `early_valid`.
- R3: Only region code 0 (RAM) may set `early_valid`. Codes 1 (device I/O), 2 and 3 never do.
- R4: A load never sets `early_valid` if any store-buffer entry with its `sb_valid` bit set has `sb_addr[AW-1:3]` equal to `req_addr[AW-1:3]`.
- R5: When `rd_hit` is low in the cycle after the request, `early_valid` is low for that load and `late_valid` is low for it as well.
- R6: A request sampled at clock edge E puts its early result on the outputs after edge E+1 and its late result after edge E+2. Both valid flags stay low when no request was sampled.
- R7: Whenever `early_valid` is high, `late_valid` is high in the next cycle and `late_data` equals the `early_data` of the previous cycle.
- R8: A 32-bit load returns byte lane `req_addr[2]` of `rd_data` (the upper half when that bit is 1). Bits 63:32 of the result are copies of bit 31 when `req_sext` is 1 and zero when it is 0.
- R9: The late result for every size takes its bytes from `rd_data` starting at byte `req_addr[2:0]`. Bytes past byte 7 read as zero. The result is extended from its top bit when `req_sext` is 1 and zero-filled when it is 0. A 64-bit load ignores `req_sext`.
- R10: While `rst_n` is low, and in the first cycle after it, both valid flags and both data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A load is issued this cycle |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 doubleword |
| req_sext | input | 1 | 1 sign-extends, 0 zero-extends the result |
| req_addr | input | AW | Byte address of the load |
| req_region | input | 2 | Memory region: 0 RAM, 1 device I/O, 2 and 3 other |
| sb_valid | input | SB_DEPTH | Store-buffer entries that are occupied |
| sb_addr | input | SB_DEPTH x AW | Byte address of each store-buffer entry |
| rd_hit | input | 1 | Cache hit for the load issued in the previous cycle |
| rd_data | input | 64 | Aligned doubleword from the cache array for that load |
| early_valid | output | 1 | Early result may be consumed |
| early_data | output | 64 | Early load result |
| late_valid | output | 1 | Normal-latency result is valid |
| late_data | output | 64 | Normal-latency load result |

## Verification
The assertions assume that `rd_hit` and `rd_data` arrive exactly one cycle after the request they belong to. They also assume that the store-buffer inputs describe the buffer as it stands in the request cycle. On these assumptions the past values of the request and buffer ports decide each qualification. The stimulus holds to these assumptions by construction. The bench records each request it issues and returns that request's hit flag and doubleword in the following cycle. It drives the store-buffer vectors in the same cycle as the request they are meant to conflict with. Conflicting entries are placed deliberately, both inside and outside the load's doubleword.

// File: rtl/ldq_pkg.sv
// Shared encodings for the early load result qualifier.
// Assumes a 64-bit data path and byte addressing.
package ldq_pkg;

    localparam int DATA_W = 64;
    localparam int BYTES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DWRD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RG_RAM  = 2'd0,
        RG_IO   = 2'd1,
        RG_RSV2 = 2'd2,
        RG_RSV3 = 2'd3
    } region_e;

    // Per-load information carried down the pipeline
    typedef struct packed {
        logic             valid;
        logic [1:0]       size;
        logic             sext;
        logic [OFF_W-1:0] off;
        logic             fast;
    } ld_meta_t;

endpackage

// File: rtl/ldq_eligibility.sv
// Combinational test that decides whether an issuing load may take the
// short path. The test covers size, natural alignment, RAM region, and the
// absence of a store-buffer entry in the same doubleword.
// Assumes the store-buffer inputs are current for the issue cycle.
module ldq_eligibility
    import ldq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int SB_DEPTH = 4
) (
    input  logic [1:0]                  size,
    input  logic [AW-1:0]               addr,
    input  logic [1:0]                  region,
    input  logic [SB_DEPTH-1:0]         sb_valid,
    input  logic [SB_DEPTH-1:0][AW-1:0] sb_addr,
    output logic                        eligible
);
    localparam int TAG_LO = OFF_W;

    logic [SB_DEPTH-1:0] sb_match;
    logic                size_ok;
    logic                align_ok;
    logic                region_ok;
    logic                raw_hazard;

    // One doubleword comparator per store-buffer entry
    for (genvar g = 0; g < SB_DEPTH; g++) begin : g_sb_cmp
        assign sb_match[g] = sb_valid[g] &&
                             (sb_addr[g][AW-1:TAG_LO] == addr[AW-1:TAG_LO]);
    end

    // Size and natural-alignment screen
    always_comb begin
        size_ok  = (size == SZ_WORD) || (size == SZ_DWRD);
        align_ok = (size == SZ_DWRD) ? (addr[OFF_W-1:0] == '0)
                                     : (addr[1:0] == 2'b00);
    end

    // Combine the individual conditions
    always_comb begin
        region_ok  = (region == RG_RAM);
        raw_hazard = |sb_match;
        eligible   = size_ok && align_ok && region_ok && !raw_hazard;
    end

endmodule

// File: rtl/ldq_format.sv
// Extracts and extends a load result from an aligned doubleword.
// FAST=1 builds the narrow word/doubleword selector used early; it assumes
// a qualified (aligned 32/64-bit) access and needs only the upper offset bit.
// FAST=0 builds the general byte shifter used by the normal-latency path.
module ldq_format
    import ldq_pkg::*;
#(
    parameter bit FAST = 1'b0,
    localparam int SW  = FAST ? 1 : OFF_W
) (
    input  logic [DATA_W-1:0] dword,
    input  logic [SW-1:0]     sel,
    input  logic [1:0]        size,
    input  logic              sext,
    output logic [DATA_W-1:0] result
);

    if (FAST) begin : g_fast
        logic [31:0] word;

        // Pick the aligned half, then extend it or pass the doubleword
        always_comb begin
            word = sel[SW-1] ? dword[63:32] : dword[31:0];
            if (size == SZ_DWRD)
                result = dword;
            else
                result = {{32{sext & word[31]}}, word};
        end
    end else begin : g_full
        logic [DATA_W-1:0] shifted;

        // Byte shift with zero fill, then width mask and extension
        always_comb begin
            shifted = dword >> {sel, 3'b000};
            unique case (size)
                SZ_BYTE: result = {{56{sext & shifted[7]}},  shifted[7:0]};
                SZ_HALF: result = {{48{sext & shifted[15]}}, shifted[15:0]};
                SZ_WORD: result = {{32{sext & shifted[31]}}, shifted[31:0]};
                default: result = shifted;
            endcase
        end
    end

endmodule

// File: rtl/load_early_fwd.sv
// Early load result qualifier. A load is sampled at issue (edge E). The
// cache returns the hit flag and doubleword in the next cycle. A qualifying
// hit is registered as the early result at E+1, and every hit is
// registered as the normal result at E+2.
// Assumes rd_hit/rd_data belong to the load sampled one edge earlier.
module load_early_fwd
    import ldq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int SB_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [1:0]                  req_size,
    input  logic                        req_sext,
    input  logic [AW-1:0]               req_addr,
    input  logic [1:0]                  req_region,
    input  logic [SB_DEPTH-1:0]         sb_valid,
    input  logic [SB_DEPTH-1:0][AW-1:0] sb_addr,
    input  logic                        rd_hit,
    input  logic [63:0]                 rd_data,
    output logic                        early_valid,
    output logic [63:0]                 early_data,
    output logic                        late_valid,
    output logic [63:0]                 late_data
);

    logic              issue_ok;
    ld_meta_t          ex2_meta;
    ld_meta_t          ex3_meta;
    logic              ex3_hit;
    logic [DATA_W-1:0] ex3_dword;
    logic [DATA_W-1:0] fast_word;
    logic [DATA_W-1:0] full_word;

    ldq_eligibility #(
        .AW       (AW),
        .SB_DEPTH (SB_DEPTH)
    ) u_elig (
        .size     (req_size),
        .addr     (req_addr),
        .region   (req_region),
        .sb_valid (sb_valid),
        .sb_addr  (sb_addr),
        .eligible (issue_ok)
    );

    // Issue stage register: capture the load and its qualification
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex2_meta <= '0;
        end else begin
            ex2_meta.valid <= req_valid;
            ex2_meta.size  <= req_size;
            ex2_meta.sext  <= req_sext;
            ex2_meta.off   <= req_addr[OFF_W-1:0];
            ex2_meta.fast  <= req_valid && issue_ok;
        end
    end

    ldq_format #(
        .FAST (1'b1)
    ) u_fmt_fast (
        .dword  (rd_data),
        .sel    (ex2_meta.off[OFF_W-1]),
        .size   (ex2_meta.size),
        .sext   (ex2_meta.sext),
        .result (fast_word)
    );

    // Early result register: qualified load that also hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_valid <= 1'b0;
            early_data  <= '0;
        end else begin
            early_valid <= ex2_meta.fast && rd_hit;
            early_data  <= fast_word;
        end
    end

    // Second stage register: hold array data for the normal path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex3_meta  <= '0;
            ex3_hit   <= 1'b0;
            ex3_dword <= '0;
        end else begin
            ex3_meta  <= ex2_meta;
            ex3_hit   <= rd_hit;
            ex3_dword <= rd_data;
        end
    end

    ldq_format #(
        .FAST (1'b0)
    ) u_fmt_full (
        .dword  (ex3_dword),
        .sel    (ex3_meta.off),
        .size   (ex3_meta.size),
        .sext   (ex3_meta.sext),
        .result (full_word)
    );

    // Normal-latency result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            late_valid <= 1'b0;
            late_data  <= '0;
        end else begin
            late_valid <= ex3_meta.valid && ex3_hit;
            late_data  <= full_word;
        end
    end

endmodule

// File: rtl/ldq_chk.sv
// Property checker for load_early_fwd, attached by bind. It recomputes the
// store-buffer conflict from the ports and relates outputs to past inputs.
// Assumes rd_hit is returned one cycle after its request.
module ldq_chk
    import ldq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int SB_DEPTH = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic [1:0]                  req_size,
    input logic [AW-1:0]               req_addr,
    input logic [1:0]                  req_region,
    input logic [SB_DEPTH-1:0]         sb_valid,
    input logic [SB_DEPTH-1:0][AW-1:0] sb_addr,
    input logic                        rd_hit,
    input logic                        early_valid,
    input logic [63:0]                 early_data,
    input logic                        late_valid,
    input logic [63:0]                 late_data
);
    logic conflict_now;

    // Any occupied store entry in the same doubleword as the request
    always_comb begin
        conflict_now = 1'b0;
        for (int i = 0; i < SB_DEPTH; i++)
            if (sb_valid[i] && sb_addr[i][AW-1:3] == req_addr[AW-1:3])
                conflict_now = 1'b1;
    end

    // R1
    size_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |-> $past(req_size, 2) >= 2'd2);

    // R2
    align_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |-> (($past(req_size, 2) == 2'd3)
                         ? ($past(req_addr[2:0], 2) == 3'd0)
                         : ($past(req_addr[1:0], 2) == 2'd0)));

    // R3
    region_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |-> $past(req_region, 2) == 2'd0);

    // R4
    store_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |-> !$past(conflict_now, 2));

    // R5
    miss_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |-> $past(rd_hit));

    // R6
    early_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |-> $past(req_valid, 2));

    // R6
    late_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        late_valid |-> $past(req_valid, 3));

    // R7
    paths_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |=> late_valid && late_data == $past(early_data));

endmodule

bind load_early_fwd ldq_chk #(
    .AW       (AW),
    .SB_DEPTH (SB_DEPTH)
) u_ldq_chk (.*);

// File: tb/test_load_early_fwd.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural per-cycle model of both result paths.
module test_load_early_fwd;
    localparam int AW = 32;
    localparam int SB = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  req_valid = 1'b0;
    logic [1:0]            req_size = '0;
    logic                  req_sext = 1'b0;
    logic [AW-1:0]         req_addr = '0;
    logic [1:0]            req_region = '0;
    logic [SB-1:0]         sb_valid = '0;
    logic [SB-1:0][AW-1:0] sb_addr = '0;
    logic                  rd_hit = 1'b0;
    logic [63:0]           rd_data = '0;
    logic                  early_valid;
    logic [63:0]           early_data;
    logic                  late_valid;
    logic [63:0]           late_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          v;
        int          sz;
        bit          sx;
        logic [31:0] a;
        int          rg;
        bit          raw;
        bit          hit;
        logic [63:0] d;
    } rq_t;

    rq_t hist[4];
    int  k = 0;
    bit  prev_ev = 1'b0;
    logic [63:0] prev_ed = '0;

    always #2.5 clk = ~clk;

    load_early_fwd #(.AW(AW), .SB_DEPTH(SB)) i_load_early_fwd (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
        .req_sext(req_sext), .req_addr(req_addr), .req_region(req_region),
        .sb_valid(sb_valid), .sb_addr(sb_addr), .rd_hit(rd_hit),
        .rd_data(rd_data), .early_valid(early_valid), .early_data(early_data),
        .late_valid(late_valid), .late_data(late_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, k);
        end
    endtask

    function automatic bit aligned(rq_t r);
        return (r.sz == 3) ? (r.a[2:0] == 3'd0) : (r.a[1:0] == 2'd0);
    endfunction

    function automatic bit exp_early(rq_t r);
        return r.v && r.sz >= 2 && aligned(r) && r.rg == 0 && !r.raw && r.hit;
    endfunction

    function automatic string early_tag(rq_t r);
        if (!r.v) return "R6";
        if (r.sz < 2) return "R1";
        if (!aligned(r)) return "R2";
        if (r.rg != 0) return "R3";
        if (r.raw) return "R4";
        if (!r.hit) return "R5";
        return "R6";
    endfunction

    // Reference extraction: byte by byte with zero fill, then extension
    function automatic logic [63:0] ref_fmt(rq_t r);
        logic [63:0] res = '0;
        int nb = 1 << r.sz;
        int off = int'(r.a[2:0]);
        for (int i = 0; i < nb; i++)
            if (off + i < 8) res[i*8 +: 8] = r.d[(off+i)*8 +: 8];
        if (r.sx && nb < 8 && res[nb*8-1])
            for (int b = nb * 8; b < 64; b++) res[b] = 1'b1;
        return res;
    endfunction

    // One cycle: compare outputs, return array data, issue next load
    task automatic step(input rq_t nr, input logic [SB-1:0] sv,
                        input logic [SB-1:0][AW-1:0] sa);
        rq_t re = hist[(k + 3) % 4];
        rq_t rl = hist[(k + 2) % 4];
        bit  ee = exp_early(re);
        bit  le = rl.v && rl.hit;
        chk(early_valid == ee, early_tag(re), 64'(early_valid), 64'(ee));
        if (ee && early_valid)
            chk(early_data == ref_fmt(re), (re.sz == 2) ? "R8" : "R7",
                early_data, ref_fmt(re));
        chk(late_valid == le, rl.v ? "R5" : "R6", 64'(late_valid), 64'(le));
        if (le && late_valid)
            chk(late_data == ref_fmt(rl), (rl.sz == 2) ? "R8" : "R9",
                late_data, ref_fmt(rl));
        // R7: late result equals the early result of the previous cycle
        if (prev_ev)
            chk(late_valid && late_data == prev_ed, "R7", late_data, prev_ed);
        prev_ev = early_valid;
        prev_ed = early_data;

        rd_hit  = hist[k % 4].hit;
        rd_data = hist[k % 4].d;

        nr.raw = 1'b0;
        for (int i = 0; i < SB; i++)
            if (sv[i] && sa[i][AW-1:3] == nr.a[AW-1:3]) nr.raw = 1'b1;
        hist[(k + 1) % 4] = nr;
        req_valid  = nr.v;
        req_size   = 2'(nr.sz);
        req_sext   = nr.sx;
        req_addr   = nr.a;
        req_region = 2'(nr.rg);
        sb_valid   = sv;
        sb_addr    = sa;
        k++;
        @(negedge clk);
    endtask

    function automatic rq_t mk(bit v, int sz, bit sx, logic [31:0] a, int rg, bit hit);
        rq_t r;
        r.v = v; r.sz = sz; r.sx = sx; r.a = a; r.rg = rg; r.raw = 1'b0;
        r.hit = hit; r.d = {$urandom(), $urandom()};
        return r;
    endfunction

    task automatic dir(input rq_t r, input bit conflict);
        logic [SB-1:0][AW-1:0] sa = '0;
        logic [SB-1:0]         sv = '0;
        if (conflict) begin
            sv[2] = 1'b1;
            sa[2] = {r.a[31:3], 3'b101};
        end else begin
            sv[1] = 1'b1;
            sa[1] = r.a + 32'd8;
        end
        step(r, sv, sa);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            hist[i] = mk(1'b0, 0, 1'b0, '0, 0, 1'b0);
        end
        repeat (3) @(negedge clk);
        // R10: outputs cleared during reset
        chk(!early_valid && !late_valid, "R10", {early_valid, late_valid}, 0);
        chk(early_data == 0 && late_data == 0, "R10", early_data | late_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!early_valid && !late_valid, "R10", {early_valid, late_valid}, 0);

        // Directed corner cases
        dir(mk(1, 3, 0, 32'h40, 0, 1), 0);   // R6 qualifying doubleword
        dir(mk(1, 2, 1, 32'h44, 0, 1), 0);   // R8 upper word, sign
        dir(mk(1, 2, 0, 32'h48, 0, 1), 0);   // R8 lower word, zero
        dir(mk(1, 0, 1, 32'h50, 0, 1), 0);   // R1 byte
        dir(mk(1, 1, 0, 32'h52, 0, 1), 0);   // R1 half
        dir(mk(1, 2, 1, 32'h62, 0, 1), 0);   // R2 misaligned word
        dir(mk(1, 3, 0, 32'h64, 0, 1), 0);   // R2 word-aligned doubleword
        dir(mk(1, 3, 0, 32'h70, 1, 1), 0);   // R3 device region
        dir(mk(1, 2, 0, 32'h78, 2, 1), 0);   // R3 other region
        dir(mk(1, 3, 0, 32'h80, 0, 1), 1);   // R4 same doubleword store
        dir(mk(1, 2, 0, 32'h88, 0, 0), 0);   // R5 miss
        dir(mk(1, 1, 1, 32'h97, 0, 1), 0);   // R9 half crossing end
        dir(mk(0, 3, 0, 32'hA0, 0, 1), 0);   // R6 idle
        dir(mk(1, 3, 1, 32'hA8, 0, 1), 0);   // R9 sext ignored for 64-bit

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            rq_t r;
            logic [SB-1:0]         sv;
            logic [SB-1:0][AW-1:0] sa;
            logic [31:0] a = 32'($urandom_range(0, 255));
            if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
            if ($urandom_range(0, 2) != 0) a[2] = 1'b0;
            r = mk($urandom_range(0, 5) != 0, int'($urandom_range(0, 3)),
                   1'($urandom_range(0, 1)), a,
                   ($urandom_range(0, 4) == 0) ? int'($urandom_range(1, 3)) : 0,
                   $urandom_range(0, 5) != 0);
            sv = SB'($urandom_range(0, (1 << SB) - 1)) & SB'($urandom_range(0, (1 << SB) - 1));
            for (int i = 0; i < SB; i++) sa[i] = 32'($urandom_range(0, 255));
            step(r, sv, sa);
        end
        for (int n = 0; n < 4; n++)
            dir(mk(0, 0, 0, '0, 0, 0), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule